// File: doc/BRIEF.md
# Parity Code Packer and Unpacker for a Four-Error-Correcting Flash ECC

This block moves the eight 10-bit parity values of a four-error-correcting flash ECC between two forms. The first form is four 32-bit parity words, each holding two values. The second form is the 10-byte code stored for every 512-byte chunk.

- **Pack mode.** Parity words arrive on a valid/ready word stream, and code bytes leave one at a time on a valid/ready byte stream. The work runs in two passes. Each pass takes two words and then sends five bytes.
- **Unpack mode.** Ten stored code bytes arrive on a valid/ready byte stream. The eight 10-bit values leave on a valid/ready value stream toward the decoder's load port, value 7 first and value 0 last.

A one-cycle `start` pulse sets the mode. The block then runs by itself through these states:

- `ST_IDLE`: waiting for `start`.
- `ST_PK_TAKE`: accepting the two parity words of a pass.
- `ST_PK_GIVE`: emitting the five bytes of a pass.
- `ST_UN_TAKE`: accepting the ten code bytes.
- `ST_UN_GIVE`: emitting the values in descending index order.

Transitions:

- **start-pack:** `ST_IDLE`→`ST_PK_TAKE`.
- **start-unpack:** `ST_IDLE`→`ST_UN_TAKE`.
- **pass-filled:** `ST_PK_TAKE`→`ST_PK_GIVE`, taken after the second word of a pass.
- **next-pass:** `ST_PK_GIVE`→`ST_PK_TAKE`, taken after byte 4.
- **pack-finish:** `ST_PK_GIVE`→`ST_IDLE`, taken after byte 9.
- **code-filled:** `ST_UN_TAKE`→`ST_UN_GIVE`, taken after byte 9.
- **unpack-finish:** `ST_UN_GIVE`→`ST_IDLE`, taken after value 0.

Top module: `parity_code_packer`

## Requirements
- R1: While reset is held, `busy`, `done`, `word_ready`, `byte_valid`, `code_ready` and `val_valid` are all 0.
- R2: `mode` is sampled only when `start` is high in the idle state: 0 selects pack and 1 selects unpack. `start` and `mode` have no effect on the running operation while `busy` is high.
- R3: From each parity word only bits [9:0] (first value) and bits [25:16] (second value) contribute to the code. All other bits are ignored.
- R4: For the words p0, p1 of a pass, the five bytes leave in this order:
  - p0[7:0]
  - {p0[21:16], p0[9:8]}
  - {p1[3:0], p0[25:22]}
  - {p1[17:16], p1[9:4]}
  - p1[25:18]
  The first pass uses words 0 and 1 (bytes 0–4), and the second pass uses words 2 and 3 (bytes 5–9).
- R5: In pack mode exactly two words are accepted before each group of five bytes. `word_ready` stays low while bytes of a pass are pending, so byte n is emitted only after 2*(n/5+1) words have been accepted.
- R6: In unpack mode, code byte i fills bits [8i+7:8i] of an 80-bit stream, and value k is stream bits [10k+9:10k].
- R7: Unpacked values leave in descending index order, value 7 first and value 0 last.
- R8: While an output is valid and not ready, it stays valid and its data stays unchanged, with no byte or value lost or repeated.
- R9: `done` is high for exactly one cycle, the cycle after the final output handshake, with `busy` already low. A `start` given in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 1 | 0 = pack, 1 = unpack; sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| word_valid | input | 1 | Parity word offered |
| word_ready | output | 1 | Parity word accepted |
| word_data | input | 32 | Parity word (two 10-bit fields) |
| byte_valid | output | 1 | Packed code byte offered |
| byte_ready | input | 1 | Packed code byte taken |
| byte_data | output | 8 | Packed code byte |
| code_valid | input | 1 | Stored code byte offered |
| code_ready | output | 1 | Stored code byte accepted |
| code_data | input | 8 | Stored code byte |
| val_valid | output | 1 | Unpacked value offered |
| val_ready | input | 1 | Unpacked value taken |
| val_data | output | 10 | Unpacked 10-bit value |

## Verification
Two functions can fall in the same cycle:

- **Finish and restart.** The completion of one operation and the acceptance of the next `start` share the `done` cycle. The bench provokes this by raising `start` with unpack selected in the cycle where it sees `done` after a pack. One cycle later it requires `busy` and `code_ready` high and the whole unpacked sequence correct.
- **Start while busy.** A `start` can arrive while an operation is still running. The bench injects such a pulse with the opposite mode a few cycles into a run and judges it only by the fact that every emitted byte or value still matches its expected value.

// File: rtl/pcp_pkg.sv
`timescale 1ns/1ps
package pcp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PK_TAKE = 3'd1,
        ST_PK_GIVE = 3'd2,
        ST_UN_TAKE = 3'd3,
        ST_UN_GIVE = 3'd4
    } pcp_state_e;

    typedef enum logic {
        MODE_PACK   = 1'b0,
        MODE_UNPACK = 1'b1
    } pcp_mode_e;

endpackage

// File: rtl/pcp_field_extract.sv
`timescale 1ns/1ps
// Pulls the two parity fields out of one register word, low field first.
module pcp_field_extract #(
    parameter int WORD_W = 32,
    parameter int VAL_W  = 10,
    parameter int HI_LSB = 16
) (
    input  logic [WORD_W-1:0]  word_i,
    output logic [2*VAL_W-1:0] pair_o
);
    logic unused_word_bits;

    assign pair_o           = {word_i[HI_LSB +: VAL_W], word_i[0 +: VAL_W]};
    assign unused_word_bits = ^word_i;

endmodule

// File: rtl/pcp_lane_mux.sv
`timescale 1ns/1ps
// Selects one fixed-width lane out of a flat bus; out-of-range selects give zero.
module pcp_lane_mux #(
    parameter int LANE_W = 8,
    parameter int NLANES = 10,
    parameter int SEL_W  = 4
) (
    input  logic [LANE_W*NLANES-1:0] bus_i,
    input  logic [SEL_W-1:0]         sel_i,
    output logic [LANE_W-1:0]        lane_o
);
    logic [LANE_W-1:0] lanes [NLANES];

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign lanes[g] = bus_i[g*LANE_W +: LANE_W];
    end

    always_comb begin
        lane_o = '0;
        for (int i = 0; i < NLANES; i++) begin
            if (sel_i == SEL_W'(i)) lane_o = lanes[i];
        end
    end

endmodule

// File: rtl/pcp_buffer.sv
`timescale 1ns/1ps
// Shared code buffer: written in value-pair slots (pack) or in bytes (unpack).
module pcp_buffer #(
    parameter int TOTAL_W = 80,
    parameter int SLOT_W  = 20,
    parameter int BYTE_W  = 8,
    parameter int NSLOT   = 4,
    parameter int NBYTE   = 10,
    parameter int SI_W    = 2,
    parameter int BI_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_we,
    input  logic [SI_W-1:0]    slot_idx,
    input  logic [SLOT_W-1:0]  slot_data,
    input  logic               byte_we,
    input  logic [BI_W-1:0]    byte_idx,
    input  logic [BYTE_W-1:0]  byte_data,
    output logic [TOTAL_W-1:0] bits_o
);
    logic [TOTAL_W-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                if (slot_we && slot_idx == SI_W'(s)) bits_q[s*SLOT_W +: SLOT_W] <= slot_data;
            end
            for (int b = 0; b < NBYTE; b++) begin
                if (byte_we && byte_idx == BI_W'(b)) bits_q[b*BYTE_W +: BYTE_W] <= byte_data;
            end
        end
    end

    assign bits_o = bits_q;

    // Only one mode fills the buffer at a time.
    assert_one_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_we && byte_we))
        else $error("slot and byte writes in the same cycle");

endmodule

// File: rtl/parity_code_packer.sv
`timescale 1ns/1ps
module parity_code_packer
    import pcp_pkg::*;
#(
    parameter int VAL_W  = 10,
    parameter int NVAL   = 8,
    parameter int WORD_W = 32,
    parameter int HI_LSB = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    output logic              busy,
    output logic              done,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              code_valid,
    output logic              code_ready,
    input  logic [BYTE_W-1:0] code_data,
    output logic              val_valid,
    input  logic              val_ready,
    output logic [VAL_W-1:0]  val_data
);
    localparam int TOTAL_W = VAL_W * NVAL;
    localparam int NBYTES  = TOTAL_W / BYTE_W;
    localparam int NWORDS  = NVAL / 2;
    localparam int SLOT_W  = 2 * VAL_W;
    localparam int NPASS   = 2;
    localparam int BPP     = NBYTES / NPASS;
    localparam int WI_W    = $clog2(NWORDS);
    localparam int BI_W    = $clog2(NBYTES);
    localparam int VI_W    = $clog2(NVAL);
    localparam int PB_W    = $clog2(BPP);

    pcp_state_e        state_q, state_d;
    logic [WI_W-1:0]   widx_q;
    logic [BI_W-1:0]   bidx_q;
    logic [PB_W-1:0]   pb_q;
    logic [VI_W-1:0]   vidx_q;
    logic              done_q;

    logic              w_hs, b_hs, c_hs, v_hs;
    logic              pass_end, last_byte, last_hs;
    logic [SLOT_W-1:0] pair;
    logic [TOTAL_W-1:0] code_bits;

    assign w_hs      = word_valid && word_ready;
    assign b_hs      = byte_valid && byte_ready;
    assign c_hs      = code_valid && code_ready;
    assign v_hs      = val_valid && val_ready;
    assign pass_end  = (pb_q == PB_W'(BPP - 1));
    assign last_byte = (bidx_q == BI_W'(NBYTES - 1));
    assign last_hs   = (state_q == ST_PK_GIVE && b_hs && last_byte)
                     || (state_q == ST_UN_GIVE && v_hs && vidx_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (pcp_mode_e'(mode) == MODE_UNPACK) ? ST_UN_TAKE : ST_PK_TAKE;
            end
            ST_PK_TAKE: begin
                // two words per pass: odd word index closes the pass
                if (w_hs && widx_q[0]) state_d = ST_PK_GIVE;
            end
            ST_PK_GIVE: begin
                if (b_hs && pass_end) state_d = last_byte ? ST_IDLE : ST_PK_TAKE;
            end
            ST_UN_TAKE: begin
                if (c_hs && last_byte) state_d = ST_UN_GIVE;
            end
            ST_UN_GIVE: begin
                if (v_hs && vidx_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Indices and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx_q <= '0;
            bidx_q <= '0;
            pb_q   <= '0;
            vidx_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_hs;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        widx_q <= '0;
                        bidx_q <= '0;
                        pb_q   <= '0;
                        vidx_q <= VI_W'(NVAL - 1);
                    end
                end
                ST_PK_TAKE: if (w_hs) widx_q <= widx_q + 1'b1;
                ST_PK_GIVE: begin
                    if (b_hs) begin
                        bidx_q <= bidx_q + 1'b1;
                        pb_q   <= pass_end ? '0 : pb_q + 1'b1;
                    end
                end
                ST_UN_TAKE: if (c_hs) bidx_q <= bidx_q + 1'b1;
                ST_UN_GIVE: if (v_hs) vidx_q <= vidx_q - 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        word_ready = (state_q == ST_PK_TAKE);
        byte_valid = (state_q == ST_PK_GIVE);
        code_ready = (state_q == ST_UN_TAKE);
        val_valid  = (state_q == ST_UN_GIVE);
    end

    pcp_field_extract #(
        .WORD_W (WORD_W),
        .VAL_W  (VAL_W),
        .HI_LSB (HI_LSB)
    ) u_fields (
        .word_i (word_data),
        .pair_o (pair)
    );

    pcp_buffer #(
        .TOTAL_W (TOTAL_W),
        .SLOT_W  (SLOT_W),
        .BYTE_W  (BYTE_W),
        .NSLOT   (NWORDS),
        .NBYTE   (NBYTES),
        .SI_W    (WI_W),
        .BI_W    (BI_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_we   (w_hs),
        .slot_idx  (widx_q),
        .slot_data (pair),
        .byte_we   (c_hs),
        .byte_idx  (bidx_q),
        .byte_data (code_data),
        .bits_o    (code_bits)
    );

    pcp_lane_mux #(
        .LANE_W (BYTE_W),
        .NLANES (NBYTES),
        .SEL_W  (BI_W)
    ) u_byte_mux (
        .bus_i  (code_bits),
        .sel_i  (bidx_q),
        .lane_o (byte_data)
    );

    pcp_lane_mux #(
        .LANE_W (VAL_W),
        .NLANES (NVAL),
        .SEL_W  (VI_W)
    ) u_val_mux (
        .bus_i  (code_bits),
        .sel_i  (vidx_q),
        .lane_o (val_data)
    );

    assert_hold_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)))
        else $error("byte dropped or changed under backpressure");

    assert_hold_val_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (val_valid && !val_ready) |=> (val_valid && $stable(val_data)))
        else $error("value dropped or changed under backpressure");

    assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_ready, byte_valid, code_ready, val_valid}))
        else $error("more than one stream active");

    assert_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(byte_valid) && busy) |-> word_ready)
        else $error("pass end did not return to word intake");

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)))
        else $error("done without a finishing operation");

endmodule

// File: tb/sim_parity_code_packer.sv
`timescale 1ns/1ps
module sim_parity_code_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic        busy, done;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [31:0] word_data = '0;
    logic        byte_valid;
    logic        byte_ready = 1'b0;
    logic [7:0]  byte_data;
    logic        code_valid = 1'b0;
    logic        code_ready;
    logic [7:0]  code_data = '0;
    logic        val_valid;
    logic        val_ready = 1'b0;
    logic [9:0]  val_data;

    parity_code_packer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .busy(busy), .done(done),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .code_valid(code_valid), .code_ready(code_ready), .code_data(code_data),
        .val_valid(val_valid), .val_ready(val_ready), .val_data(val_data)
    );

    always #4 clk = ~clk;

    int          n_checks = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [31:0] wds [4];
    logic [7:0]  cb [10];
    int          words_acc;
    int          rdy_pct = 70;
    bit          poke_start = 0;
    string       tag_b = "R4";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R4: byte formulas per pass
    function automatic logic [7:0] exp_byte(int i);
        logic [31:0] p0, p1;
        p0 = wds[2*(i/5)];
        p1 = wds[2*(i/5)+1];
        case (i % 5)
            0:       return p0[7:0];
            1:       return {p0[21:16], p0[9:8]};
            2:       return {p1[3:0], p0[25:22]};
            3:       return {p1[17:16], p1[9:4]};
            default: return p1[25:18];
        endcase
    endfunction

    // R6: little-endian byte stream, 10-bit value slices
    function automatic logic [9:0] exp_val(int k);
        logic [79:0] s;
        for (int i = 0; i < 10; i++) s[8*i +: 8] = cb[i];
        return s[10*k +: 10];
    endfunction

    task automatic poke();
        repeat (3) @(negedge clk);
        start = 1'b1;
        mode  = $urandom;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed_words();
        int k = 0;
        while (k < 4) begin
            @(negedge clk);
            word_valid = ($urandom_range(99) < 75);
            word_data  = wds[k];
            #1;
            if (word_valid && word_ready) begin
                words_acc++;
                k++;
            end
        end
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = $urandom;
    endtask

    task automatic collect_bytes();
        int n = 0;
        bit held = 0;
        logic [7:0] held_d = '0;
        while (n < 10) begin
            @(negedge clk);
            byte_ready = ($urandom_range(99) < rdy_pct);
            #1;
            if (held) begin
                chk(byte_valid && byte_data == held_d, "R8", {23'd0, byte_valid, byte_data}, {24'd1, held_d});
                held = 0;
            end
            if (byte_valid && byte_ready) begin
                chk(byte_data == exp_byte(n), tag_b, byte_data, exp_byte(n));
                chk(words_acc == 2*(n/5+1), "R5", words_acc, 2*(n/5+1));
                n++;
            end else if (byte_valid) begin
                held   = 1;
                held_d = byte_data;
            end
        end
        @(negedge clk);
        byte_ready = 1'b0;
        #1;
        chk(done === 1'b1 && busy === 1'b0, "R9", {done, busy}, 2'b10);
    endtask

    task automatic feed_code();
        int k = 0;
        while (k < 10) begin
            @(negedge clk);
            code_valid = ($urandom_range(99) < 75);
            code_data  = cb[k];
            #1;
            if (code_valid && code_ready) k++;
        end
        @(negedge clk);
        code_valid = 1'b0;
        code_data  = $urandom;
    endtask

    task automatic collect_vals();
        int n = 0;
        bit held = 0;
        logic [9:0] held_d = '0;
        while (n < 8) begin
            @(negedge clk);
            val_ready = ($urandom_range(99) < rdy_pct);
            #1;
            if (held) begin
                chk(val_valid && val_data == held_d, "R8", {21'd0, val_valid, val_data}, {22'd1, held_d});
                held = 0;
            end
            if (val_valid && val_ready) begin
                chk(val_data == exp_val(7-n), poke_start ? "R2" : "R6 R7", val_data, exp_val(7-n));
                n++;
            end else if (val_valid) begin
                held   = 1;
                held_d = val_data;
            end
        end
        @(negedge clk);
        val_ready = 1'b0;
        #1;
        chk(done === 1'b1 && busy === 1'b0, "R9", {done, busy}, 2'b10);
    endtask

    task automatic run_pack(input bit already);
        words_acc = 0;
        tag_b = poke_start ? "R2" : tag_b;
        if (!already) begin
            @(negedge clk); start = 1'b1; mode = 1'b0;
            @(negedge clk); start = 1'b0; mode = $urandom;
        end
        fork
            feed_words();
            collect_bytes();
            if (poke_start) poke();
        join
    endtask

    task automatic run_unpack(input bit already);
        if (!already) begin
            @(negedge clk); start = 1'b1; mode = 1'b1;
            @(negedge clk); start = 1'b0; mode = $urandom;
        end
        fork
            feed_code();
            collect_vals();
            if (poke_start) poke();
        join
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5151));
        repeat (3) @(negedge clk);
        #1;
        chk({busy, done, word_ready, byte_valid, code_ready, val_valid} == 6'b0, "R1",
            {busy, done, word_ready, byte_valid, code_ready, val_valid}, 6'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: all field bits set, junk set too -> all bytes FF
        for (int i = 0; i < 4; i++) wds[i] = 32'hFFFF_FFFF;
        tag_b = "R3";
        run_pack(0);
        chk(exp_byte(9) == 8'hFF, "R3", exp_byte(9), 8'hFF);
        // R3: only bits outside the fields set -> all bytes 00
        for (int i = 0; i < 4; i++) wds[i] = 32'hFC00_FC00;
        run_pack(0);

        // random packs, varying backpressure, some with a start pulse while busy
        for (int r = 0; r < 16; r++) begin
            for (int i = 0; i < 4; i++) wds[i] = $urandom;
            rdy_pct    = (r % 3 == 0) ? 100 : ((r % 3 == 1) ? 30 : 70);
            poke_start = (r % 4 == 3);
            tag_b      = "R4";
            run_pack(0);
        end
        poke_start = 0;

        // directed unpack
        for (int i = 0; i < 10; i++) cb[i] = 8'(8'h11 * i + 1);
        rdy_pct = 100;
        run_unpack(0);
        for (int r = 0; r < 16; r++) begin
            for (int i = 0; i < 10; i++) cb[i] = $urandom;
            rdy_pct    = (r % 3 == 0) ? 100 : ((r % 3 == 1) ? 30 : 70);
            poke_start = (r % 4 == 2);
            run_unpack(0);
        end
        poke_start = 0;

        // R9: start issued in the done cycle of a pack launches an unpack
        for (int i = 0; i < 4; i++) wds[i] = $urandom;
        tag_b   = "R4";
        rdy_pct = 60;
        run_pack(0);
        for (int i = 0; i < 10; i++) cb[i] = $urandom;
        start = 1'b1;
        mode  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode  = 1'b0;
        #1;
        chk(busy === 1'b1 && code_ready === 1'b1, "R9", {busy, code_ready}, 2'b11);
        run_unpack(1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule